// File: doc/BRIEF.md
# Snooping Write-Back Cache Line Coherence Controller

This block keeps the coherence state of a small direct-mapped tag array for one write-back cache on an atomic snooping bus. Each line is in one of four states: invalid, shared, exclusive-clean or modified. Processor reads and writes are looked up against the array. A hit completes at once. A miss, or a write to a shared copy, raises a bus request that holds until the bus grants it. The grant cycle is the whole transaction: in that cycle the combined shared line is sampled and the array is updated.

At the same time the block watches transactions that other caches place on the bus. For each one it reports on two snoop-response outputs whether it holds a valid copy and whether that copy is dirty and will be supplied. It then demotes or invalidates its own copy. A line filled while no other cache claims it becomes exclusive-clean. A later write to it turns it modified with no bus traffic. A write to a shared copy costs only an address-only upgrade.

The bus guarantees that a grant and a snoop never fall in the same cycle. Addresses are line addresses. The low `IDX_W` bits select the set and the remaining bits form the tag.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid: a snoop to any address drives `snp_shared` and `snp_modified` low, and `bus_req` is low.
- R2: A read miss issues a read (`bus_cmd`=0). In the grant cycle the line fills as shared if `bus_shared_in` is high and as exclusive-clean if it is low.
- R3: A processor write that hits an exclusive-clean or modified line completes with no bus request and leaves the line modified.
- R4: A processor write that hits a shared line issues an upgrade (`bus_cmd`=2) at the line's address. The write completes after the grant and leaves the line modified.
- R5: A processor write miss issues a read-exclusive (`bus_cmd`=1), and the line fills as modified.
- R6: During a snoop (`snp_valid` high) `snp_shared` is high exactly when the snooped address is held valid, and `snp_modified` is high exactly when it is held modified.
- R7: A snooped read (`snp_cmd`=0) that hits a modified or exclusive-clean line leaves it shared.
- R8: A snooped read-exclusive (`snp_cmd`=1) or upgrade (`snp_cmd`=2) that hits any valid line leaves it invalid.
- R9: A miss whose set holds a modified line of another tag first issues a write-back (`bus_cmd`=3) at the victim's address and then the fill. A miss whose victim is shared or exclusive-clean issues only the fill.
- R10: If a pending upgrade's line is invalidated by a snoop before the grant, the request becomes a read-exclusive for the same address.
- R11: No processor access completes (`cpu_done`) in a cycle with `snp_valid` high. It completes once the snoop is gone.
- R12: A read that hits any valid line completes with no bus request and leaves the line's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_done | output | 1 | Access completes at this clock edge |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_gnt | input | 1 | Requested transaction is performed in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches, valid with `bus_gnt` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds a valid copy of `snp_addr` |
| snp_modified | output | 1 | This cache holds a dirty copy and supplies it |

## Verification
A wrong line state shows at the ports at the latest on the next access to that line. A snoop exposes it in the same cycle through `snp_shared` and `snp_modified`. A processor write exposes it through whether it completes silently, raises an upgrade or raises a read-exclusive. An eviction exposes it through whether a write-back precedes the fill. So the bench follows each state change with a snoop or an access that reveals the state. The fill-state choice and the upgrade-to-read-exclusive conversion are observed in the first cycle the request is visible.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_modified
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  logic [TAG_W-1:0]  tag_q [SETS];
  logic [1:0]        st_q  [SETS];
  logic              busy_q;
  logic [1:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;

  wire [IDX_W-1:0] cidx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] ctag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] sidx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] stag = snp_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] ridx = addr_q[IDX_W-1:0];

  wire chit = st_q[cidx] != ST_I && tag_q[cidx] == ctag;
  wire shit = st_q[sidx] != ST_I && tag_q[sidx] == stag;
  wire snp_kill = snp_valid && shit && (snp_cmd == C_RDX || snp_cmd == C_UPG);

  assign cpu_done     = !busy_q && cpu_req && !snp_valid && chit &&
                        !(cpu_we && st_q[cidx] == ST_S);
  assign bus_req      = busy_q;
  assign bus_cmd      = cmd_q;
  assign bus_addr     = addr_q;
  assign snp_shared   = snp_valid && shit;
  assign snp_modified = snp_valid && shit && st_q[sidx] == ST_M;

  wire start = !busy_q && cpu_req && !snp_valid && !cpu_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
      busy_q <= 1'b0;
      cmd_q  <= C_RD;
      addr_q <= '0;
    end else begin
      if (snp_valid && shit) begin
        if (snp_cmd == C_RD && (st_q[sidx] == ST_M || st_q[sidx] == ST_E))
          st_q[sidx] <= ST_S;
        else if (snp_cmd == C_RDX || snp_cmd == C_UPG)
          st_q[sidx] <= ST_I;
      end
      if (cpu_done && cpu_we)
        st_q[cidx] <= ST_M;
      if (start) begin
        busy_q <= 1'b1;
        if (chit) begin
          cmd_q  <= C_UPG;
          addr_q <= cpu_addr;
        end else if (st_q[cidx] == ST_M) begin
          cmd_q  <= C_WB;
          addr_q <= {tag_q[cidx], cidx};
        end else begin
          cmd_q  <= cpu_we ? C_RDX : C_RD;
          addr_q <= cpu_addr;
        end
      end
      if (busy_q && snp_valid && snp_addr == addr_q) begin
        if (cmd_q == C_WB && shit)
          busy_q <= 1'b0;
        else if (cmd_q == C_UPG && snp_kill)
          cmd_q <= C_RDX;
      end
      if (busy_q && bus_gnt) begin
        busy_q <= 1'b0;
        case (cmd_q)
          C_RD: begin
            st_q[ridx]  <= bus_shared_in ? ST_S : ST_E;
            tag_q[ridx] <= addr_q[ADDR_W-1:IDX_W];
          end
          C_RDX: begin
            st_q[ridx]  <= ST_M;
            tag_q[ridx] <= addr_q[ADDR_W-1:IDX_W];
          end
          C_UPG:   st_q[ridx] <= ST_M;
          default: st_q[ridx] <= ST_I;
        endcase
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !bus_req);  // R1
  AST_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == C_RD && !bus_shared_in |=> st_q[ridx] == ST_E);  // R2
  AST_WRITE_HIT_M: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_we |=> st_q[$past(cidx)] == ST_M);  // R3
  AST_UPG_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_cmd == C_UPG |-> st_q[ridx] == ST_S);  // R10
  AST_SNP_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill |=> st_q[$past(sidx)] == ST_I);  // R8
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_cmd == C_WB |-> st_q[ridx] == ST_M);  // R9
  AST_NO_DONE_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_done);  // R11
  AST_REQ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !snp_valid |=> !bus_req || $stable(bus_addr));  // R9
endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_shared_in = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_done, bus_req, snp_shared, snp_modified;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  int nchk = 0, nbad = 0, cyc = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) dut_i (.*);

  // op: 0 read, 1 write, 2 snoop read, 3 snoop read-excl, 4 snoop upgrade
  // e1/e2: bus commands expected (7 = none); wa: expected write-back address
  typedef struct packed {
    logic [2:0] op; logic [AW-1:0] addr; logic shin;
    logic [2:0] e1; logic [2:0] e2; logic esh; logic emd; logic [AW-1:0] wa;
  } vec_t;
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 12'h010, 1'b0, 3'd0, 3'd7, 1'b0, 1'b0, 12'h000},  // R2 read miss
    '{3'd1, 12'h010, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 12'h000},  // R3 silent write on E
    '{3'd2, 12'h010, 1'b0, 3'd7, 3'd7, 1'b1, 1'b1, 12'h000},  // R6 M seen
    '{3'd1, 12'h010, 1'b0, 3'd2, 3'd7, 1'b0, 1'b0, 12'h000},  // R7 R4 demoted, upgrade
    '{3'd3, 12'h010, 1'b0, 3'd7, 3'd7, 1'b1, 1'b1, 12'h000},  // R8 snoop rdx on M
    '{3'd0, 12'h010, 1'b1, 3'd0, 3'd7, 1'b0, 1'b0, 12'h000},  // R8 now miss, R2 fill S
    '{3'd0, 12'h010, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 12'h000},  // R12 read hit
    '{3'd1, 12'h010, 1'b0, 3'd2, 3'd7, 1'b0, 1'b0, 12'h000},  // R2 R4 shared fill
    '{3'd0, 12'h018, 1'b0, 3'd3, 3'd0, 1'b0, 1'b0, 12'h010},  // R9 dirty eviction
    '{3'd2, 12'h010, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 12'h000},  // R9 victim gone
    '{3'd0, 12'h010, 1'b0, 3'd0, 3'd7, 1'b0, 1'b0, 12'h000},  // R9 clean eviction
    '{3'd2, 12'h018, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 12'h000},  // R9 clean victim gone
    '{3'd2, 12'h010, 1'b0, 3'd7, 3'd7, 1'b1, 1'b0, 12'h000},  // R6 R7 E seen
    '{3'd1, 12'h010, 1'b0, 3'd2, 3'd7, 1'b0, 1'b0, 12'h000},  // R7 E demoted
    '{3'd1, 12'h021, 1'b0, 3'd1, 3'd7, 1'b0, 1'b0, 12'h000},  // R5 write miss
    '{3'd2, 12'h021, 1'b0, 3'd7, 3'd7, 1'b1, 1'b1, 12'h000},  // R5 filled M
    '{3'd4, 12'h021, 1'b0, 3'd7, 3'd7, 1'b1, 1'b0, 12'h000},  // R8 snoop upgrade on S
    '{3'd0, 12'h021, 1'b0, 3'd0, 3'd7, 1'b0, 1'b0, 12'h000},  // R8 miss after upgrade
    '{3'd1, 12'h029, 1'b0, 3'd1, 3'd7, 1'b0, 1'b0, 12'h000},  // R5 R9 E victim silent
    '{3'd2, 12'h029, 1'b0, 3'd7, 3'd7, 1'b1, 1'b1, 12'h000}   // R5 R6
  };

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic serve(input logic shin, output logic [2:0] c1, output logic [2:0] c2,
                       output logic [AW-1:0] a1);
    int n = 0;
    c1 = 3'd7; c2 = 3'd7; a1 = '0;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (cpu_done) begin
        @(posedge clk); #1 cpu_req = 0;
        @(negedge clk);
        return;
      end
      if (bus_req) begin
        if (n == 0) begin c1 = {1'b0, bus_cmd}; a1 = bus_addr; end
        else c2 = {1'b0, bus_cmd};
        n++;
        bus_gnt = 1; bus_shared_in = shin;
        @(posedge clk); #1 bus_gnt = 0;
      end else @(posedge clk);
      @(negedge clk);
    end
    cpu_req = 0;
    chk("access timeout", 1, 0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       output logic sh, output logic md);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1 sh = snp_shared; md = snp_modified;
    @(posedge clk); #1 snp_valid = 0;
    @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic shin,
                        output logic [2:0] c1, output logic [2:0] c2, output logic [AW-1:0] a1);
    cpu_req = 1; cpu_we = we; cpu_addr = a;
    serve(shin, c1, c2, a1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nbad++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [2:0] c1, c2;
    logic [AW-1:0] a1;
    logic sh, md;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus_req", bus_req, 0);
    snoop(2'd0, 12'h010, sh, md);
    chk("R1 snp_shared", sh, 0);
    chk("R1 snp_modified", md, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op < 3'd2) begin
        access(VEC[i].op[0], VEC[i].addr, VEC[i].shin, c1, c2, a1);
        chk($sformatf("vec %0d first bus cmd", i), c1, VEC[i].e1);
        chk($sformatf("vec %0d second bus cmd", i), c2, VEC[i].e2);
        if (VEC[i].e1 == 3'd3) chk($sformatf("vec %0d R9 write-back addr", i), a1, VEC[i].wa);
      end else begin
        snoop(VEC[i].op == 3'd2 ? 2'd0 : (VEC[i].op == 3'd3 ? 2'd1 : 2'd2), VEC[i].addr, sh, md);
        chk($sformatf("vec %0d R6 snp_shared", i), sh, VEC[i].esh);
        chk($sformatf("vec %0d R6 snp_modified", i), md, VEC[i].emd);
      end
    end

    // R10: pending upgrade invalidated by a snoop turns into read-exclusive
    access(1'b0, 12'h042, 1'b1, c1, c2, a1);
    chk("R10 setup fill", c1, 0);
    cpu_req = 1; cpu_we = 1; cpu_addr = 12'h042;
    @(posedge clk); @(negedge clk); #1;
    chk("R10 upgrade raised", bus_req, 1);
    chk("R10 upgrade cmd", bus_cmd, 2);
    snoop(2'd1, 12'h042, sh, md);
    chk("R10 snoop sees shared", sh, 1);
    #1 chk("R10 converted cmd", bus_cmd, 1);
    chk("R10 addr kept", bus_addr, 12'h042);
    serve(1'b0, c1, c2, a1);
    snoop(2'd0, 12'h042, sh, md);
    chk("R10 line modified", md, 1);

    // R11: a hit is held off during a snoop cycle
    cpu_req = 1; cpu_we = 0; cpu_addr = 12'h010;
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 12'h018;
    #1 chk("R11 done blocked", cpu_done, 0);
    chk("R11 no bus request", bus_req, 0);
    @(posedge clk); #1 snp_valid = 0;
    @(negedge clk); #1;
    chk("R11 done after snoop", cpu_done, 1);
    serve(1'b0, c1, c2, a1);
    chk("R12 hit needs no bus", c1, 7);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule